// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

This block is one 16-bit timer channel. An up-counter advances either on an internal count enable or on rising edges of an external event input, and it wraps freely. A general register compares against the counter or captures it. A buffer register stands behind the general register. In buffered compare mode it holds the next compare value, which moves into the general register at each match. In buffered capture mode it keeps the capture before the latest one.

Software sets up the channel through a small register port: a write strobe, a 2-bit address and write data, with read data returned combinationally for the addressed register. A capture input and an external event input are asynchronous. Each passes through a two-flop synchronizer and an edge detector before it has any effect. In compare mode a match shows as a one-cycle pulse on the match output.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset the counter, general register, buffer register and control register all read 0, and match_o is 0.
- R2: With control bit 2 clear, the counter rises by 1 on every clock edge where cnt_en_i is 1 and holds otherwise. It wraps from 0xFFFF to 0x0000.
- R3: A write to address 0 loads the counter. When it falls in the same cycle as a count tick, the written value wins over the increment.
- R4: With control bit 2 set, the counter advances exactly once per rising edge of ext_evt_i. ext_evt_i passes through a two-flop synchronizer, and cnt_en_i is ignored.
- R5: In compare mode (control bit 0 clear), match_o is high for exactly the one cycle after a count tick that moves the counter off a value equal to the general register.
- R6: In compare mode with buffering on (control bit 1 set), the general register takes the buffer value on the same edge that raises match_o.
- R7: With buffering off, a match or capture never changes the buffer register, and a match leaves the general register unchanged.
- R8: In capture mode (control bit 0 set), a rising edge on cap_i loads the counter into the general register. The load happens on the third clock edge after cap_i rises.
- R9: In capture mode with buffering on, the same capture edge moves the old general-register value into the buffer register.
- R10: In capture mode match_o stays 0.
- R11: Address 1 reads and writes the general register, address 2 the buffer register, and address 3 the 3-bit control register (zero-extended on read).
- R12: A software write to the general register in the same cycle as a hardware transfer into it wins, and the write value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 counter, 1 general, 2 buffer, 3 control) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cnt_en_i | input | 1 | Internal count enable |
| ext_evt_i | input | 1 | External count event, asynchronous |
| cap_i | input | 1 | Capture input, asynchronous |
| match_o | output | 1 | Compare match pulse |

## Verification
The assertions check on every cycle these rules: counter increment and hold, write priority, the buffer staying untouched when buffering is off, the capture push chain, the compare preload, the silence of match_o in capture mode, and that a match pulse always follows an advance past the general register. Only the bench scenarios can show the things that need longer context. These are the exact three-edge capture latency, the count of external events across synchronization, the wrap of the counter, and the sequence of compare values fed through the buffer over successive matches.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {
    REG_CNT = 2'd0,
    REG_GEN = 2'd1,
    REG_BUF = 2'd2,
    REG_CTL = 2'd3
  } reg_addr_e;

  // bit0 cap_mode, bit1 buf_en, bit2 ext_clk
  typedef struct packed {
    logic ext_clk;
    logic buf_en;
    logic cap_mode;
  } ctl_t;

  localparam int CTL_W = 3;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= in_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)        cnt_d = wdata_i;
    else if (tick_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i) |=> cnt_q == W'($past(cnt_q) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q)); // R2
  AST_CNT_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i)); // R3
endmodule

// File: rtl/cc_gen_buf.sv
module cc_gen_buf #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gen_wr_i,
  input  logic         buf_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         buf_en_i,
  input  logic         cmp_load_i,
  input  logic         cap_evt_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] buf_o
);
  logic [W-1:0] gen_q, gen_d;
  logic [W-1:0] buf_q, buf_d;

  always_comb begin
    gen_d = gen_q;
    if (gen_wr_i)                    gen_d = wdata_i;
    else if (cap_evt_i)              gen_d = cnt_i;
    else if (cmp_load_i && buf_en_i) gen_d = buf_q;
  end

  always_comb begin
    buf_d = buf_q;
    if (buf_wr_i)                   buf_d = wdata_i;
    else if (cap_evt_i && buf_en_i) buf_d = gen_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= '0;
      buf_q <= '0;
    end else begin
      gen_q <= gen_d;
      buf_q <= buf_d;
    end
  end

  assign gen_o = gen_q;
  assign buf_o = buf_q;

  AST_BUF_HW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_en_i && !buf_wr_i) |=> $stable(buf_q)); // R7
  AST_GEN_NO_PRELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_en_i && !gen_wr_i && !cap_evt_i) |=> $stable(gen_q)); // R7
  AST_CAP_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && buf_en_i && !gen_wr_i && !buf_wr_i)
      |=> (gen_q == $past(cnt_i)) && (buf_q == $past(gen_q))); // R9
  AST_CMP_PRELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_load_i && buf_en_i && !cap_evt_i && !gen_wr_i) |=> gen_q == $past(buf_q)); // R6
  AST_GEN_SW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr_i |=> gen_q == $past(wdata_i)); // R12
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             cnt_en_i,
  input  logic             ext_evt_i,
  input  logic             cap_i,
  output logic             match_o
);
  localparam int PAD_W = CNT_W - CTL_W;

  ctl_t             ctl_q;
  logic [CNT_W-1:0] cnt_q, gen_q, buf_q;
  logic             ext_rise, cap_rise;
  logic             tick, cnt_wr, gen_wr, buf_wr, ctl_wr;
  logic             hit, cap_evt, match_q;

  assign cnt_wr = wr_en_i && (reg_addr_e'(addr_i) == REG_CNT);
  assign gen_wr = wr_en_i && (reg_addr_e'(addr_i) == REG_GEN);
  assign buf_wr = wr_en_i && (reg_addr_e'(addr_i) == REG_BUF);
  assign ctl_wr = wr_en_i && (reg_addr_e'(addr_i) == REG_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
  end

  cc_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (ext_evt_i),
    .rise_o (ext_rise)
  );

  cc_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (cap_i),
    .rise_o (cap_rise)
  );

  assign tick    = ctl_q.ext_clk ? ext_rise : cnt_en_i;
  assign hit     = !ctl_q.cap_mode && tick && (cnt_q == gen_q);
  assign cap_evt = ctl_q.cap_mode && cap_rise;

  cc_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .tick_i  (tick),
    .cnt_o   (cnt_q)
  );

  cc_gen_buf #(.W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gen_wr_i   (gen_wr),
    .buf_wr_i   (buf_wr),
    .wdata_i    (wdata_i),
    .buf_en_i   (ctl_q.buf_en),
    .cmp_load_i (hit),
    .cap_evt_i  (cap_evt),
    .cnt_i      (cnt_q),
    .gen_o      (gen_q),
    .buf_o      (buf_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= hit;
  end
  assign match_o = match_q;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_CNT: rdata_o = cnt_q;
      REG_GEN: rdata_o = gen_q;
      REG_BUF: rdata_o = buf_q;
      default: rdata_o = {{PAD_W{1'b0}}, ctl_q};
    endcase
  end

  AST_NO_MATCH_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl_q.cap_mode) |-> !match_o); // R10
  AST_MATCH_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !$past(cnt_wr)) |-> cnt_q == CNT_W'($past(gen_q) + 1'b1)); // R5
  AST_CAP_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.cap_mode && !cap_rise && !gen_wr) |=> $stable(gen_q)); // R8
endmodule

// File: tb/cc_timer_chan_tb_top.sv
module cc_timer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cnt_en = 1'b0;
  logic        ext_evt = 1'b0;
  logic        cap = 1'b0;
  logic        match;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  cc_timer_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_en_i(cnt_en),
    .ext_evt_i(ext_evt), .cap_i(cap), .match_o(match)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rd_chk("R1 cnt", 2'd0, 16'h0);
    rd_chk("R1 gen", 2'd1, 16'h0);
    rd_chk("R1 buf", 2'd2, 16'h0);
    rd_chk("R1 ctl", 2'd3, 16'h0);
    chk("R1 match", {31'h0, match}, 32'h0);
  endtask

  task automatic t_regs();
    wr(2'd3, 16'hFFFF);
    rd_chk("R11 ctl zero-ext", 2'd3, 16'h0007);
    wr(2'd3, 16'h0);
    wr(2'd1, 16'hA5A5);
    wr(2'd2, 16'h5A5A);
    rd_chk("R11 gen", 2'd1, 16'hA5A5);
    rd_chk("R11 buf", 2'd2, 16'h5A5A);
  endtask

  task automatic t_count();
    wr(2'd3, 16'h0);
    wr(2'd1, 16'hF000);
    wr(2'd0, 16'h0010);
    tick_n(5);
    rd_chk("R2 inc", 2'd0, 16'h0015);
    repeat (4) @(negedge clk);
    rd_chk("R2 hold", 2'd0, 16'h0015);
    wr(2'd0, 16'hFFFF);
    tick_n(1);
    rd_chk("R2 wrap", 2'd0, 16'h0000);
    // R3: write and tick together
    @(negedge clk);
    cnt_en = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 16'h0100;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    rd_chk("R3 write wins", 2'd0, 16'h0100);
  endtask

  task automatic t_ext();
    wr(2'd3, 16'h0004);
    wr(2'd0, 16'h0);
    @(negedge clk); cnt_en = 1'b1;
    repeat (8) @(negedge clk);
    rd_chk("R4 cnt_en ignored", 2'd0, 16'h0);
    for (int i = 0; i < 3; i++) begin
      ext_evt = 1'b1;
      repeat (2) @(negedge clk);
      ext_evt = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cnt_en = 1'b0;
    rd_chk("R4 three events", 2'd0, 16'h3);
    wr(2'd3, 16'h0);
  endtask

  task automatic t_cmp_buf();
    int hits = 0;
    wr(2'd3, 16'h0002);
    wr(2'd1, 16'h0005);
    wr(2'd2, 16'h0009);
    wr(2'd0, 16'h0003);
    tick_n(2);
    chk("R5 no early match", {31'h0, match}, 32'h0);
    tick_n(1);
    chk("R5 match pulse", {31'h0, match}, 32'h1);
    rd_chk("R6 preload gen", 2'd1, 16'h0009);
    rd_chk("R5 cnt past gen", 2'd0, 16'h0006);
    @(negedge clk);
    chk("R5 one cycle", {31'h0, match}, 32'h0);
    wr(2'd2, 16'h000C);
    @(negedge clk); cnt_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (match) hits++;
    end
    cnt_en = 1'b0;
    chk("R5 match count", hits, 32'd2);
    rd_chk("R6 second preload", 2'd1, 16'h000C);
  endtask

  task automatic t_cmp_nobuf();
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0002);
    wr(2'd2, 16'h0077);
    wr(2'd0, 16'h0000);
    tick_n(3);
    chk("R5 unbuffered match", {31'h0, match}, 32'h1);
    rd_chk("R7 gen kept", 2'd1, 16'h0002);
    rd_chk("R7 buf kept", 2'd2, 16'h0077);
  endtask

  task automatic t_cap_buf();
    int m = 0;
    wr(2'd3, 16'h0003);
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'h0011);
    wr(2'd2, 16'h0000);
    @(negedge clk); cap = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_chk("R8 not before third edge", 2'd1, 16'h0011);
    @(negedge clk);
    rd_chk("R8 captured", 2'd1, 16'h0040);
    rd_chk("R9 pushed", 2'd2, 16'h0011);
    cap = 1'b0;
    wr(2'd0, 16'h0080);
    @(negedge clk); cap = 1'b1;
    repeat (4) @(negedge clk);
    cap = 1'b0;
    rd_chk("R8 second capture", 2'd1, 16'h0080);
    rd_chk("R9 second push", 2'd2, 16'h0040);
    // R10: counting through gen value in capture mode
    wr(2'd0, 16'h007E);
    @(negedge clk); cnt_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (match) m++;
    end
    cnt_en = 1'b0;
    chk("R10 no match in capture", m, 32'd0);
  endtask

  task automatic t_cap_nobuf();
    wr(2'd3, 16'h0001);
    wr(2'd2, 16'h0055);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0020);
    @(negedge clk); cap = 1'b1;
    repeat (4) @(negedge clk);
    cap = 1'b0;
    rd_chk("R8 unbuffered capture", 2'd1, 16'h0020);
    rd_chk("R7 buf untouched on capture", 2'd2, 16'h0055);
  endtask

  task automatic t_sw_wins();
    wr(2'd3, 16'h0002);
    wr(2'd0, 16'h0007);
    wr(2'd1, 16'h0007);
    wr(2'd2, 16'h0030);
    @(negedge clk);
    cnt_en = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 16'h0099;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    chk("R12 match still flagged", {31'h0, match}, 32'h1);
    rd_chk("R12 write kept", 2'd1, 16'h0099);
    rd_chk("R12 buf kept", 2'd2, 16'h0030);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_count();
    t_ext();
    t_cmp_buf();
    t_cmp_nobuf();
    t_cap_buf();
    t_cap_nobuf();
    t_sw_wins();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule